// File: doc/BRIEF.md
# Dual-Tone Warbling Alarm Driver

This block turns a system clock into the square-wave drive for a piezo sounder. Two select lines from the processor choose a low tone, a high tone, or both. With both set, the drive alternates between the two tones at a slow, fixed rate. Two further inputs, one from a low-battery detector and one from a watchdog, can sound the alarm when the processor has selected nothing. In that case the high tone is used.

The tone pitches and the warble rate are set by parameters that give the clock frequency and the wanted frequencies. Each is turned into a half-period count of clock cycles. When the tone changes, the divider starts over. The level on the drive line at that moment is held for a full half-period of the new tone, so the output never shows a short glitch. The block has no stream data path. All of its pins are plain level controls and a single drive output.

Top module: `warble_alarm_drv`

## Requirements
- R1: With only `sel_low` set, every half-period of `drive_o` lasts CLK_HZ/(2*LOW_HZ) clock cycles. LOW_HZ is intended to lie within 700..1500 Hz.
- R2: With only `sel_high` set, every half-period lasts CLK_HZ/(2*HIGH_HZ) cycles. HIGH_HZ is intended to lie within 1600..2500 Hz.
- R3: With both select lines set, the warble starts on the low tone.
- R4: While warbling, the tone swaps between low and high every CLK_HZ*5/WARBLE_DHZ cycles. WARBLE_DHZ is the warble rate in tenths of a hertz and is intended to lie within 8..20.
- R5: With `force_lowbat` set and no select line set, the high tone is produced.
- R6: With `force_wdog` set and no select line set, the high tone is produced.
- R7: When a select line is set, it chooses the tone even while a force input is active.
- R8: With no select line and no force input set, `drive_o` is low from the next clock edge onward.
- R9: On any change of tone, including a start from idle, the divider restarts. The present level of `drive_o` then lasts a further full half-period of the new tone. A start from idle therefore shows a low level for one half-period before the first rising edge.
- R10: While `rst_n` is low, `drive_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_low | input | 1 | Processor request for the low tone |
| sel_high | input | 1 | Processor request for the high tone |
| force_lowbat | input | 1 | Low-battery forced enable |
| force_wdog | input | 1 | Watchdog-timeout forced enable |
| drive_o | output | 1 | Square-wave drive to the sounder |

## Verification
The bench goes after the tone switch made in the middle of a half-period. A design that kept the old count, or flipped the level at the switch, would give a segment shorter or longer than the expected elapsed-plus-new-half length. It also checks the start from idle, where a design that began high or miscounted would move the first rising edge. The warble is sampled well inside each phase to catch a rate divider with the wrong length or the wrong starting tone. It also checks force inputs combined with a select line, because a wrong priority would give the high tone where the low tone is expected.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  typedef enum logic [1:0] {
    TONE_OFF  = 2'd0,
    TONE_LOW  = 2'd1,
    TONE_HIGH = 2'd2
  } tone_e;
endpackage

// File: rtl/alarm_warble_timer.sv
module alarm_warble_timer #(
  parameter int HALF_CYC = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic phase_o
);
  localparam int CW = $clog2(HALF_CYC + 1);
  localparam logic [CW-1:0] LIM = CW'(HALF_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic          phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !run_i) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else if (cnt_q == LIM) begin
      cnt_q   <= '0;
      phase_q <= ~phase_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign phase_o = phase_q;
endmodule

// File: rtl/alarm_tone_pick.sv
module alarm_tone_pick
  import alarm_pkg::*;
(
  input  logic  sel_low,
  input  logic  sel_high,
  input  logic  force_any,
  input  logic  phase_i,
  output logic  warble_o,
  output tone_e tone_o
);
  always_comb begin
    warble_o = sel_low & sel_high;
    if (warble_o)      tone_o = phase_i ? TONE_HIGH : TONE_LOW;
    else if (sel_low)  tone_o = TONE_LOW;
    else if (sel_high) tone_o = TONE_HIGH;
    else if (force_any) tone_o = TONE_HIGH;
    else               tone_o = TONE_OFF;
  end
endmodule

// File: rtl/alarm_tone_div.sv
module alarm_tone_div
  import alarm_pkg::*;
#(
  parameter int LOW_HALF  = 500,
  parameter int HIGH_HALF = 250
) (
  input  logic  clk,
  input  logic  rst_n,
  input  tone_e tone_i,
  output tone_e cur_o,
  output logic  drive_o
);
  localparam int MAXH = (LOW_HALF > HIGH_HALF) ? LOW_HALF : HIGH_HALF;
  localparam int CW   = $clog2(MAXH + 1);
  localparam logic [CW-1:0] LOW_LIM  = CW'(LOW_HALF - 1);
  localparam logic [CW-1:0] HIGH_LIM = CW'(HIGH_HALF - 1);

  tone_e         cur_q;
  logic [CW-1:0] cnt_q;
  logic          drv_q;
  logic [CW-1:0] lim;

  assign lim = (tone_i == TONE_LOW) ? LOW_LIM : HIGH_LIM;

  always_ff @(posedge clk) begin
    if (!rst_n || tone_i == TONE_OFF) begin
      cur_q <= TONE_OFF;
      cnt_q <= '0;
      drv_q <= 1'b0;
    end else if (tone_i != cur_q) begin
      cur_q <= tone_i;   // restart, level held
      cnt_q <= '0;
    end else if (cnt_q == lim) begin
      cnt_q <= '0;
      drv_q <= ~drv_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cur_o   = cur_q;
  assign drive_o = drv_q;
endmodule

// File: rtl/warble_alarm_drv.sv
module warble_alarm_drv
  import alarm_pkg::*;
#(
  parameter int CLK_HZ     = 1_000_000,
  parameter int LOW_HZ     = 1000,
  parameter int HIGH_HZ    = 2000,
  parameter int WARBLE_DHZ = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_low,
  input  logic sel_high,
  input  logic force_lowbat,
  input  logic force_wdog,
  output logic drive_o
);
  localparam int LOW_HALF    = CLK_HZ / (2 * LOW_HZ);
  localparam int HIGH_HALF   = CLK_HZ / (2 * HIGH_HZ);
  localparam int WARBLE_HALF = (CLK_HZ * 5) / WARBLE_DHZ;

  logic  warble_on;
  logic  warble_phase;
  tone_e want_tone;
  tone_e active_tone;

  alarm_warble_timer #(.HALF_CYC(WARBLE_HALF)) u_wtmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_i   (warble_on),
    .phase_o (warble_phase)
  );

  alarm_tone_pick u_pick (
    .sel_low   (sel_low),
    .sel_high  (sel_high),
    .force_any (force_lowbat | force_wdog),
    .phase_i   (warble_phase),
    .warble_o  (warble_on),
    .tone_o    (want_tone)
  );

  alarm_tone_div #(.LOW_HALF(LOW_HALF), .HIGH_HALF(HIGH_HALF)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .tone_i  (want_tone),
    .cur_o   (active_tone),
    .drive_o (drive_o)
  );
endmodule

// File: rtl/warble_alarm_chk.sv
module warble_alarm_chk
  import alarm_pkg::*;
#(
  parameter int MIN_HALF    = 10,
  parameter int WARBLE_HALF = 100
) (
  input logic  clk,
  input logic  rst_n,
  input logic  sel_low,
  input logic  sel_high,
  input logic  force_lowbat,
  input logic  force_wdog,
  input logic  drive_o,
  input tone_e active_tone,
  input logic  warble_phase
);
  logic        prev_drv, prev_ph;
  logic [31:0] run_len, ph_len;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_drv <= 1'b0;
      prev_ph  <= 1'b0;
      run_len  <= 32'd1;
      ph_len   <= 32'd1;
    end else begin
      prev_drv <= drive_o;
      prev_ph  <= warble_phase;
      if (drive_o != prev_drv) run_len <= 32'd1;
      else if (run_len != 32'hFFFF_FFFF) run_len <= run_len + 1;
      if (warble_phase != prev_ph) ph_len <= 32'd1;
      else if (ph_len != 32'hFFFF_FFFF) ph_len <= ph_len + 1;
    end
  end

  // R10
  reset_low_chk: assert property (@(posedge clk) !rst_n |=> !drive_o);

  // R8
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_low && !sel_high && !force_lowbat && !force_wdog) |=> !drive_o);

  // R5 R6
  force_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((force_lowbat || force_wdog) && !sel_low && !sel_high) |=> active_tone == TONE_HIGH);

  // R7
  select_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_low && !sel_high) |=> active_tone == TONE_LOW);

  // R3
  warble_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel_low && sel_high) |=> !warble_phase);

  // R4
  warble_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warble_phase && !prev_ph) |-> ph_len >= WARBLE_HALF);

  // R9
  min_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_o != prev_drv && active_tone != TONE_OFF) |-> run_len >= MIN_HALF);
endmodule

bind warble_alarm_drv warble_alarm_chk #(
  .MIN_HALF    ((HIGH_HALF < LOW_HALF) ? HIGH_HALF : LOW_HALF),
  .WARBLE_HALF (WARBLE_HALF)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .sel_low      (sel_low),
  .sel_high     (sel_high),
  .force_lowbat (force_lowbat),
  .force_wdog   (force_wdog),
  .drive_o      (drive_o),
  .active_tone  (active_tone),
  .warble_phase (warble_phase)
);

// File: tb/warble_alarm_drv_tb.sv
module warble_alarm_drv_tb;
  localparam int CLK_HZ = 40000;
  localparam int LOW_HZ = 1000;
  localparam int HIGH_HZ = 2000;
  localparam int WARBLE_DHZ = 10;
  localparam int LH = CLK_HZ / (2 * LOW_HZ);       // 20
  localparam int HH = CLK_HZ / (2 * HIGH_HZ);      // 10

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_low = 1'b0, sel_high = 1'b0, force_lowbat = 1'b0, force_wdog = 1'b0;
  logic drive_o;
  int   n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  warble_alarm_drv #(.CLK_HZ(CLK_HZ), .LOW_HZ(LOW_HZ), .HIGH_HZ(HIGH_HZ),
                     .WARBLE_DHZ(WARBLE_DHZ)) u_dut (
    .clk(clk), .rst_n(rst_n), .sel_low(sel_low), .sel_high(sel_high),
    .force_lowbat(force_lowbat), .force_wdog(force_wdog), .drive_o(drive_o));

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // negedges until drive_o differs from its value at the call
  task automatic next_change(output int n);
    logic v;
    v = drive_o;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (drive_o == v && n < 100000);
  endtask

  task automatic check_half(input string req, input int exp);
    int n;
    next_change(n);
    next_change(n);
    check(req, n, exp);
  endtask

  task automatic set_in(input logic l, input logic h, input logic b, input logic w);
    sel_low = l; sel_high = h; force_lowbat = b; force_wdog = w;
  endtask

  initial begin
    int n;
    repeat (5) @(negedge clk);
    check("R10 drive in reset", int'(drive_o), 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    check("R8 idle after reset", int'(drive_o), 0);

    // R9 start from idle: low level for one low half, rise at edge LH+1
    set_in(1, 0, 0, 0);
    next_change(n);
    check("R9 first rise from idle", n, LH + 1);
    // R1
    check_half("R1 low half a", LH);
    check_half("R1 low half b", LH);
    check_half("R1 low half c", LH);

    // R9 switch low->high 4 cycles into a segment: 5 + HH
    next_change(n);
    repeat (4) @(negedge clk);
    set_in(0, 1, 0, 0);
    next_change(n);
    check("R9 switch segment", n + 4, 5 + HH);
    // R2
    check_half("R2 high half a", HH);
    check_half("R2 high half b", HH);
    check_half("R2 high half c", HH);

    // R8
    set_in(0, 0, 0, 0);
    @(negedge clk);
    check("R8 off next cycle", int'(drive_o), 0);
    repeat (50) @(negedge clk);
    check("R8 off held", int'(drive_o), 0);

    // R5
    set_in(0, 0, 1, 0);
    check_half("R5 lowbat high tone a", HH);
    check_half("R5 lowbat high tone b", HH);
    // R6
    set_in(0, 0, 0, 1);
    check_half("R6 wdog high tone a", HH);
    check_half("R6 wdog high tone b", HH);
    // R7
    set_in(1, 0, 0, 1);
    check_half("R7 select beats force", LH);
    set_in(1, 0, 1, 1);
    check_half("R7 select beats both forces", LH);

    // R3 / R4 warble: low for 20000 cycles, then high, then low
    set_in(0, 0, 0, 0);
    repeat (5) @(negedge clk);
    set_in(1, 1, 0, 0);
    repeat (1000) @(negedge clk);
    check_half("R3 warble starts low", LH);
    repeat (20000) @(negedge clk);
    check_half("R4 warble second phase high", HH);
    check_half("R4 warble second phase high b", HH);
    repeat (19500) @(negedge clk);
    check_half("R4 warble third phase low", LH);

    set_in(0, 0, 0, 0);
    @(negedge clk);
    check("R8 off after warble", int'(drive_o), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule